// File: doc/BRIEF.md
# Rotating Register Window Controller

This block holds the control state for a windowed general register file of 64 physical registers. They are grouped into 16 quads of four, and a program sees 16 logical registers, A0 to A15, at any moment. The controller keeps a 4-bit window base and a 16-bit window-start mask with one bit per physical quad. It turns every logical register number into a physical index. It also carries out the four window operations that an instruction decoder hands it: call, entry, return and rotate.

A set bit in the start mask marks the lowest quad of a live call frame. The size of that frame is read from the clear bits that follow the set bit. Two conditions stop an operation and raise a trap code instead. A register access that reaches past another live frame raises an overflow (spill) trap. A return to a frame whose quads are no longer resident raises an underflow (fill) trap. A trap handler reads and rewrites the base and the mask through dedicated write ports. The faulting instruction is then restarted, and it may trap again.

The block has no register storage of its own, no memory path and no decoder. Its caller gives it the A0, A1 and return-address values and applies the register writes it requests.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the window base is 0, the start mask is 0x0001, the stored call increment is 0 and no trap is signalled.
- R2: The physical index of logical register r is 4*((base + floor(r/4)) mod 16) + (r mod 4), on the combinational output in the same cycle.
- R3: A rotate (op code 4) adds its 4-bit two's-complement amount to the base modulo 16 and leaves the mask unchanged.
- R4: A call (op code 1) stores its 2-bit increment in the call-increment state and requests a write of the return value. That value carries the increment in its top two bits and the supplied low 30 address bits below it. The base and mask do not change.
- R5: An entry (op code 2) sets the base to base + stored increment (mod 16) and sets the mask bit of the new base. It requests a write to the physical index of the new A1 with data equal to the old A1 minus the frame amount.
- R6: A return (op code 3) computes target = base minus the top two bits of A0 (mod 16). If the target's mask bit is set, the return clears the mask bit of the current base and moves the base to the target.
- R7: If the target's mask bit is clear, the return raises a fill trap, code {1, n-1}, where n is the top two bits of A0 (n = 0 is reported as size 1), and the base and mask stay unchanged.
- R8: An access to a register in quad offset k ≥ 1 raises a spill trap if any mask bit at offsets 1..k from the base is set. The nearest such quad is the frame reported. Its size is 1 if the next quad's bit is set, else 2 if the quad after that is set, else 3. The code is {0, size-1}.
- R9: A trap is reported on trap_valid/trap_code in the cycle after the faulting one. The faulting cycle changes no state and asserts no write request. A spill takes priority over any operation presented with the access.
- R10: A software write to the base or the mask takes effect at the next edge. In that cycle any operation and access check are dropped: no trap and no write request.
- R11: After a handler clears the reported frame's mask bit, repeating the same access traps on the next nearer frame, if one remains, and otherwise proceeds without a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A window operation is presented |
| op_kind | input | 3 | 1 call, 2 entry, 3 return, 4 rotate, 0 none |
| op_inc | input | 2 | Call increment (1, 2 or 3 quads) |
| op_rot | input | 4 | Signed rotate amount in quads |
| op_frame | input | 32 | Entry frame amount subtracted from A1 |
| a0_inc | input | 2 | Top two bits of the current A0 |
| a1_val | input | 32 | Current A1 value |
| ret_low | input | 30 | Low 30 bits of the return address for a call |
| acc_valid | input | 1 | A logical register access is checked this cycle |
| acc_reg | input | 4 | Logical register number |
| acc_preg | output | 6 | Physical index of acc_reg |
| ret_wr_en | output | 1 | Request to write the return value into A0 of the caller |
| ret_wr_data | output | 32 | Return value with increment in its top bits |
| a1_wr_en | output | 1 | Request to write the new A1 on entry |
| a1_wr_preg | output | 6 | Physical index of the new A1 |
| a1_wr_data | output | 32 | Old A1 minus the frame amount |
| trap_valid | output | 1 | Trap reported for the previous cycle |
| trap_code | output | 3 | {fill, size-1} |
| wb_wr_en | input | 1 | Software write of the window base |
| wb_wr_data | input | 4 | New window base |
| ws_wr_en | input | 1 | Software write of the start mask |
| ws_wr_data | input | 16 | New start mask |
| win_base | output | 4 | Current window base |
| win_start | output | 16 | Current start mask |
| call_inc | output | 2 | Stored call increment |

## Verification
A wrong base shows up at once on acc_preg for every register access, and on win_base one cycle after the operation that corrupted it. A wrong mask bit can stay hidden until a later access or return crosses that quad. It then appears as a missing, extra or wrongly sized trap code one cycle after that access. The bench therefore replays a reference model on every clock and compares all outputs. It also builds frame layouts on purpose so that each of the three spill sizes, the fill path and the repeated spill sequence fall into the checked cycles.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [2:0] {
        WOP_NONE  = 3'd0,
        WOP_CALL  = 3'd1,
        WOP_ENTRY = 3'd2,
        WOP_RETW  = 3'd3,
        WOP_ROTW  = 3'd4
    } win_op_e;

    localparam int TRAP_W = 3;

    function automatic logic [TRAP_W-1:0] trap_pack(input logic is_fill, input logic [1:0] size_m1);
        return {is_fill, size_m1};
    endfunction

endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
    parameter  int NQ    = 16,
    parameter  int QREGS = 4,
    parameter  int VQ    = 4,
    localparam int QB    = $clog2(NQ),
    localparam int RQB   = $clog2(QREGS),
    localparam int LB    = $clog2(VQ * QREGS),
    localparam int PB    = $clog2(NQ * QREGS)
) (
    input  logic [QB-1:0] base,
    input  logic [LB-1:0] lreg,
    output logic [PB-1:0] preg
);

    logic [QB-1:0] phys_quad;

    // quad counter wraps naturally because NQ is a power of two
    assign phys_quad = base + QB'(lreg[LB-1:RQB]);
    assign preg      = {phys_quad, lreg[RQB-1:0]};

endmodule

// File: rtl/regwin_ovf_scan.sv
module regwin_ovf_scan #(
    parameter  int NQ = 16,
    parameter  int VQ = 4,
    localparam int QB = $clog2(NQ),
    localparam int OB = $clog2(VQ)
) (
    input  logic [NQ-1:0] ws,
    input  logic [QB-1:0] base,
    input  logic [OB-1:0] qoff,
    output logic          hit,
    output logic [1:0]    size_m1
);

    logic [VQ-1:1] cand;
    logic [QB-1:0] frame_q;
    logic [QB-1:0] next1;
    logic [QB-1:0] next2;

    // one candidate per visible quad above A0-A3
    for (genvar k = 1; k < VQ; k++) begin : g_off
        logic [QB-1:0] q_at;
        assign q_at    = base + QB'(k);
        assign cand[k] = (OB'(k) <= qoff) && ws[q_at];
    end

    // nearest owning frame wins: scan from far to near
    always_comb begin
        hit     = 1'b0;
        frame_q = '0;
        for (int k = VQ - 1; k >= 1; k--) begin
            if (cand[k]) begin
                hit     = 1'b1;
                frame_q = base + QB'(k);
            end
        end
    end

    assign next1 = frame_q + QB'(1);
    assign next2 = frame_q + QB'(2);

    always_comb begin
        if (ws[next1])      size_m1 = 2'd0;
        else if (ws[next2]) size_m1 = 2'd1;
        else                size_m1 = 2'd2;
    end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter  int NQ    = 16,
    parameter  int QREGS = 4,
    parameter  int XLEN  = 32,
    localparam int VQ    = 4,
    localparam int QB    = $clog2(NQ),
    localparam int LB    = $clog2(VQ * QREGS),
    localparam int PB    = $clog2(NQ * QREGS),
    localparam int OB    = $clog2(VQ),
    localparam int RQB   = $clog2(QREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [1:0]        op_inc,
    input  logic [QB-1:0]     op_rot,
    input  logic [XLEN-1:0]   op_frame,
    input  logic [1:0]        a0_inc,
    input  logic [XLEN-1:0]   a1_val,
    input  logic [XLEN-3:0]   ret_low,
    input  logic              acc_valid,
    input  logic [LB-1:0]     acc_reg,
    output logic [PB-1:0]     acc_preg,
    output logic              ret_wr_en,
    output logic [XLEN-1:0]   ret_wr_data,
    output logic              a1_wr_en,
    output logic [PB-1:0]     a1_wr_preg,
    output logic [XLEN-1:0]   a1_wr_data,
    output logic              trap_valid,
    output logic [TRAP_W-1:0] trap_code,
    input  logic              wb_wr_en,
    input  logic [QB-1:0]     wb_wr_data,
    input  logic              ws_wr_en,
    input  logic [NQ-1:0]     ws_wr_data,
    output logic [QB-1:0]     win_base,
    output logic [NQ-1:0]     win_start,
    output logic [1:0]        call_inc
);

    typedef struct packed {
        logic [QB-1:0]     wb;
        logic [NQ-1:0]     ws;
        logic [1:0]        cinc;
        logic              trap;
        logic [TRAP_W-1:0] tcode;
    } win_state_t;

    win_state_t st_d, st_q;

    logic          sw_any;
    logic          spill_hit;
    logic [1:0]    spill_sz;
    logic          spill_now;
    logic [QB-1:0] entry_base_d;
    logic [QB-1:0] ret_base_d;
    logic [1:0]    fill_sz_d;

    assign sw_any       = wb_wr_en | ws_wr_en;
    assign spill_now    = acc_valid & spill_hit;
    assign entry_base_d = st_q.wb + QB'(st_q.cinc);
    assign ret_base_d   = st_q.wb - QB'(a0_inc);
    assign fill_sz_d    = (a0_inc == 2'd0) ? 2'd0 : a0_inc - 2'd1;

    regwin_map #(.NQ(NQ), .QREGS(QREGS), .VQ(VQ)) u_acc_map (
        .base (st_q.wb),
        .lreg (acc_reg),
        .preg (acc_preg)
    );

    regwin_map #(.NQ(NQ), .QREGS(QREGS), .VQ(VQ)) u_a1_map (
        .base (entry_base_d),
        .lreg (LB'(1)),
        .preg (a1_wr_preg)
    );

    regwin_ovf_scan #(.NQ(NQ), .VQ(VQ)) u_scan (
        .ws      (st_q.ws),
        .base    (st_q.wb),
        .qoff    (acc_reg[LB-1:RQB]),
        .hit     (spill_hit),
        .size_m1 (spill_sz)
    );

    assign ret_wr_data = {op_inc, ret_low};
    assign a1_wr_data  = a1_val - op_frame;

    always_comb begin
        st_d       = st_q;
        st_d.trap  = 1'b0;
        st_d.tcode = '0;
        ret_wr_en  = 1'b0;
        a1_wr_en   = 1'b0;
        if (sw_any) begin
            if (wb_wr_en) st_d.wb = wb_wr_data;
            if (ws_wr_en) st_d.ws = ws_wr_data;
        end else if (spill_now) begin
            st_d.trap  = 1'b1;
            st_d.tcode = trap_pack(1'b0, spill_sz);
        end else if (op_valid) begin
            case (op_kind)
                WOP_CALL: begin
                    st_d.cinc = op_inc;
                    ret_wr_en = 1'b1;
                end
                WOP_ENTRY: begin
                    st_d.wb               = entry_base_d;
                    st_d.ws[entry_base_d] = 1'b1;
                    a1_wr_en              = 1'b1;
                end
                WOP_RETW: begin
                    if (!st_q.ws[ret_base_d]) begin
                        st_d.trap  = 1'b1;
                        st_d.tcode = trap_pack(1'b1, fill_sz_d);
                    end else begin
                        st_d.ws[st_q.wb] = 1'b0;
                        st_d.wb          = ret_base_d;
                    end
                end
                WOP_ROTW: begin
                    st_d.wb = st_q.wb + op_rot;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wb    <= '0;
            st_q.ws    <= NQ'(1);
            st_q.cinc  <= '0;
            st_q.trap  <= 1'b0;
            st_q.tcode <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_valid = st_q.trap;
    assign trap_code  = st_q.tcode;
    assign win_base   = st_q.wb;
    assign win_start  = st_q.ws;
    assign call_inc   = st_q.cinc;

    // R9
    trap_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (win_base == $past(win_base) && win_start == $past(win_start)));

    // R7
    fill_from_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_code[TRAP_W-1]) |-> $past(op_valid && op_kind == WOP_RETW));

    // R5
    entry_marks_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == WOP_ENTRY && !sw_any && !spill_now) |=> win_start[win_base]);

    // R4
    call_latches_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_wr_en |=> (call_inc == $past(op_inc)));

    // R8
    spill_size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_code[1:0] != 2'b11));

    // R10
    sw_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wr_en || ws_wr_en) |=> !trap_valid);

endmodule

// File: tb/regwin_ctrl_tb_top.sv
module regwin_ctrl_tb_top;
    import regwin_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [1:0]  op_inc;
    logic [3:0]  op_rot;
    logic [31:0] op_frame;
    logic [1:0]  a0_inc;
    logic [31:0] a1_val;
    logic [29:0] ret_low;
    logic        acc_valid;
    logic [3:0]  acc_reg;
    logic [5:0]  acc_preg;
    logic        ret_wr_en;
    logic [31:0] ret_wr_data;
    logic        a1_wr_en;
    logic [5:0]  a1_wr_preg;
    logic [31:0] a1_wr_data;
    logic        trap_valid;
    logic [2:0]  trap_code;
    logic        wb_wr_en;
    logic [3:0]  wb_wr_data;
    logic        ws_wr_en;
    logic [15:0] ws_wr_data;
    logic [3:0]  win_base;
    logic [15:0] win_start;
    logic [1:0]  call_inc;

    always #4 clk = ~clk;

    regwin_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_inc(op_inc), .op_rot(op_rot), .op_frame(op_frame), .a0_inc(a0_inc),
        .a1_val(a1_val), .ret_low(ret_low), .acc_valid(acc_valid), .acc_reg(acc_reg),
        .acc_preg(acc_preg), .ret_wr_en(ret_wr_en), .ret_wr_data(ret_wr_data),
        .a1_wr_en(a1_wr_en), .a1_wr_preg(a1_wr_preg), .a1_wr_data(a1_wr_data),
        .trap_valid(trap_valid), .trap_code(trap_code), .wb_wr_en(wb_wr_en),
        .wb_wr_data(wb_wr_data), .ws_wr_en(ws_wr_en), .ws_wr_data(ws_wr_data),
        .win_base(win_base), .win_start(win_start), .call_inc(call_inc)
    );

    int n_run  = 0;
    int n_fail = 0;

    int          m_wb;
    logic [15:0] m_ws;
    int          m_ci;
    logic        m_trap;
    int          m_tc;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        op_valid = 0; op_kind = 0; op_inc = 0; op_rot = 0; op_frame = 0;
        a0_inc = 0; a1_val = 0; ret_low = 0; acc_valid = 0; acc_reg = 0;
        wb_wr_en = 0; wb_wr_data = 0; ws_wr_en = 0; ws_wr_data = 0;
    endtask

    // one clock: compare combinational outputs, advance the model, compare state
    task automatic tick(input string tag);
        bit hit = 0;
        int fq = 0, sz = 0, tgt, n_wb, n_ci, n_tc;
        logic [15:0] n_ws;
        logic n_trap;
        bit e_ret = 0, e_a1 = 0;
        #1;
        chk("R2 physical index", acc_preg, ((m_wb + acc_reg / 4) % 16) * 4 + acc_reg % 4);
        for (int k = 1; k <= acc_reg / 4; k++) begin
            if (!hit && m_ws[(m_wb + k) % 16]) begin
                hit = 1;
                fq  = (m_wb + k) % 16;
            end
        end
        if (m_ws[(fq + 1) % 16]) sz = 1;
        else if (m_ws[(fq + 2) % 16]) sz = 2;
        else sz = 3;
        n_wb = m_wb; n_ws = m_ws; n_ci = m_ci; n_trap = 0; n_tc = 0;
        if (wb_wr_en || ws_wr_en) begin
            if (wb_wr_en) n_wb = wb_wr_data;
            if (ws_wr_en) n_ws = ws_wr_data;
        end else if (acc_valid && hit) begin
            n_trap = 1; n_tc = sz - 1;
        end else if (op_valid) begin
            if (op_kind == 3'(WOP_CALL)) begin
                n_ci = op_inc; e_ret = 1;
            end else if (op_kind == 3'(WOP_ENTRY)) begin
                n_wb = (m_wb + m_ci) % 16; n_ws[n_wb] = 1'b1; e_a1 = 1;
            end else if (op_kind == 3'(WOP_RETW)) begin
                tgt = (m_wb + 16 - a0_inc) % 16;
                if (!m_ws[tgt]) begin
                    n_trap = 1; n_tc = 4 + ((a0_inc == 0) ? 0 : a0_inc - 1);
                end else begin
                    n_ws[m_wb] = 1'b0; n_wb = tgt;
                end
            end else if (op_kind == 3'(WOP_ROTW)) begin
                n_wb = (m_wb + op_rot) % 16;
            end
        end
        chk("R4 return write request", ret_wr_en, e_ret);
        if (e_ret) chk("R4 return value", ret_wr_data, {op_inc, ret_low});
        chk("R5 A1 write request", a1_wr_en, e_a1);
        if (e_a1) begin
            chk("R5 A1 physical index", a1_wr_preg, ((m_wb + m_ci) % 16) * 4 + 1);
            chk("R5 A1 data", a1_wr_data, 32'(a1_val - op_frame));
        end
        @(posedge clk);
        #1;
        m_wb = n_wb; m_ws = n_ws; m_ci = n_ci; m_trap = n_trap; m_tc = n_tc;
        chk({tag, " base"}, win_base, m_wb);
        chk({tag, " start mask"}, win_start, m_ws);
        chk({tag, " call increment"}, call_inc, m_ci);
        chk({tag, " R9 trap flag"}, trap_valid, m_trap);
        if (m_trap) chk({tag, " trap code"}, trap_code, m_tc);
        clr();
    endtask

    task automatic do_acc(input int r, input string tag);
        acc_valid = 1; acc_reg = 4'(r); tick(tag);
    endtask
    task automatic do_rot(input int amt, input string tag);
        op_valid = 1; op_kind = 3'(WOP_ROTW); op_rot = 4'(amt); tick(tag);
    endtask
    task automatic do_call(input int inc, input logic [29:0] low, input string tag);
        op_valid = 1; op_kind = 3'(WOP_CALL); op_inc = 2'(inc); ret_low = low; tick(tag);
    endtask
    task automatic do_entry(input logic [31:0] a1, input logic [31:0] fr, input string tag);
        op_valid = 1; op_kind = 3'(WOP_ENTRY); a1_val = a1; op_frame = fr; tick(tag);
    endtask
    task automatic do_ret(input int inc, input string tag);
        op_valid = 1; op_kind = 3'(WOP_RETW); a0_inc = 2'(inc); tick(tag);
    endtask
    task automatic do_sw(input int b, input logic [15:0] m, input string tag);
        wb_wr_en = 1; wb_wr_data = 4'(b); ws_wr_en = 1; ws_wr_data = m; tick(tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clr();
        m_wb = 0; m_ws = 16'h0001; m_ci = 0; m_trap = 0; m_tc = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        chk("R1 reset base", win_base, 0);
        chk("R1 reset start mask", win_start, 16'h0001);
        chk("R1 reset call increment", call_inc, 0);
        chk("R1 reset trap", trap_valid, 0);

        for (int r = 0; r < 16; r += 5) do_acc(r, "R2 map at base 0");
        do_rot(3, "R3 rotate +3");
        do_rot(-5, "R3 rotate -5 wraps");
        do_acc(15, "R2 map wrapped");
        do_acc(6, "R2 map wrapped low");

        // software write wins over a rotate and an access
        op_valid = 1; op_kind = 3'(WOP_ROTW); op_rot = 4'd7;
        wb_wr_en = 1; wb_wr_data = 4'd0; ws_wr_en = 1; ws_wr_data = 16'h0001;
        tick("R10 write beats rotate");
        ws_wr_en = 1; ws_wr_data = 16'h0003; acc_valid = 1; acc_reg = 4'd4;
        tick("R10 write beats spill");
        do_sw(0, 16'h0001, "R10 restore");

        do_call(2, 30'h1234567, "R4 call by 2");
        do_entry(32'h1000, 32'h20, "R5 entry by 2");
        do_call(3, 30'h3ABCDEF, "R4 call by 3");
        do_entry(32'h0FE0, 32'h40, "R5 entry by 3");
        do_acc(15, "R8 no owner in reach");

        // spill chain: frames at 7 and 8 above base 5
        do_sw(5, 16'h01A0, "R10 set frames");
        do_acc(12, "R8 spill size 1");
        do_sw(5, 16'h0120, "R11 handler clears 7");
        do_acc(12, "R11 second spill size 3");
        do_sw(5, 16'h0020, "R11 handler clears 8");
        do_acc(12, "R11 retry passes");
        do_sw(5, 16'h0160, "R8 set frame at 6");
        do_acc(4, "R8 spill size 2");
        do_acc(3, "R8 low quad never spills");

        // entry blocked by a spilling access
        op_valid = 1; op_kind = 3'(WOP_ENTRY); a1_val = 32'h500; op_frame = 32'h10;
        acc_valid = 1; acc_reg = 4'd5;
        tick("R9 entry held by spill");

        do_sw(5, 16'h0025, "R6 frames at 0 2 5");
        do_ret(3, "R6 return by 3");
        do_ret(2, "R6 return by 2");
        do_sw(2, 16'h0004, "R7 caller spilled");
        do_ret(2, "R7 fill size 2");
        do_ret(1, "R7 fill size 1");
        do_ret(0, "R7 return by 0 keeps base");
        do_acc(0, "R9 trap cleared");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule